// File: doc/BRIEF.md
# Two-Wire Bus Master Transaction Controller

This block is the master side of a two-wire serial bus, modelled at the level of whole bus steps and not single bit levels. Software drives it through one write port. That port updates a control register and a data register. A 0-to-1 change of the start bit or the stop bit, or a one written to the pending interrupt flag, is a command. The block turns each command into one step toward the peer: a start, a stop, an address byte, a data byte sent, or a data byte received.

Each step appears for one clock as an event on the peer port. The event carries the peer address and the data byte. The peer answers in the same cycle with an acknowledge level and, for a read, with a data byte. A status code that describes the step is held back for a fixed number of bit-times. When it is posted, it raises the interrupt flag. Software then clears that flag to start the next step.

Top module: `twm_ctrl`

## Requirements
- R1: After reset, the enable, start, stop and acknowledge-enable outputs and the interrupt flag are 0, the data register reads 0xFF, the status reads 0xF8 (no state), and no event is emitted.
- R2: A control write with bit 0 (enable) at 0 while enabled clears start, stop, acknowledge-enable and the interrupt flag. In the next cycle the data register reads 0xFF and the status reads 0xF8. Any status still pending is discarded and never appears.
- R3: While the block is disabled, a control write that leaves bit 0 at 0 changes nothing: start (bit 1), stop (bit 2) and the interrupt flag stay as they are, no event is emitted and no status is posted.
- R4: A 0-to-1 change of control bit 2 (stop) emits a stop event (kind 4, carrying the stored peer address) only while a start is active. It always ends the transaction, so the next byte step sends an address again and the next start posts 0x08.
- R5: A 0-to-1 change of control bit 1 (start) posts status 0x10 if a start is already active and 0x08 otherwise. The status appears exactly 3 bit-times after the write, and the interrupt flag is set in the same cycle.
- R6: A write of one to control bit 7 (interrupt clear) while the flag is set, with bits 1 and 2 at 0 and no address sent yet, emits an address event (kind 1) carrying the data register. That byte becomes the peer address, and its bit 0 set means read.
- R7: An address step posts, 9 bit-times later, 0x40 or 0x48 for a read address and 0x18 or 0x20 for a write address. The first code of each pair applies when the peer acknowledged.
- R8: After the address, a byte step of a write transfer emits a write event (kind 2) with the data register value. It posts 0x28 if the peer acknowledged and 0x30 if not. Such a step only happens if the data register has been written since the last start or byte step; otherwise nothing is emitted and nothing is posted.
- R9: A byte step of a read transfer emits a read event (kind 3) whose acknowledge output equals control bit 3 (acknowledge-enable). It loads the peer's byte into the data register and posts 0x50 if bit 3 is set, 0x58 if it is not, 9 bit-times later.
- R10: The interrupt flag is cleared only by writing one to bit 7 while enabled. Writing 0 to bit 7 leaves it set.
- R11: A new command that posts a status replaces any status still pending, so only the newer code is posted.
- R12: A control write that clears the interrupt flag while setting bit 1 or bit 2 performs no byte step and emits no address or data event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 the data register |
| wr_data | input | 8 | Write value |
| ctl_en | output | 1 | Enable bit |
| ctl_start | output | 1 | Start bit |
| ctl_stop | output | 1 | Stop bit |
| ctl_ack_en | output | 1 | Acknowledge-enable bit |
| irq | output | 1 | Interrupt flag |
| data_q | output | 8 | Data register |
| status_q | output | 8 | Status code |
| evt_valid | output | 1 | An event is presented this cycle |
| evt_kind | output | 3 | 1 address, 2 write, 3 read, 4 stop |
| evt_addr | output | 8 | Peer address byte |
| evt_data | output | 8 | Byte sent on a write event, else 0 |
| evt_ack | output | 1 | Acknowledge given by the master on a read event |
| peer_ack | input | 1 | Peer acknowledge, sampled in the event cycle |
| peer_rdata | input | 8 | Peer byte for a read event, sampled in the event cycle |

## Verification
The bench builds the block with two clock cycles per bit-time. Start statuses then land 6 cycles after their command and byte statuses 18 cycles after. This keeps the check one cycle before and one cycle after each posting short. It also lets a second command fall well inside a running delay, which is how the replacement of a pending status and the loss of a pending status on disable are reached.

// File: rtl/twm_pkg.sv
// Package: shared constants and types of the two-wire master controller.
// Assumes 8-bit register and bus bytes.
package twm_pkg;

    localparam int DATA_W     = 8;
    localparam int START_BITS = 3;   // bit-times from start command to status
    localparam int BYTE_BITS  = 9;   // bit-times from byte command to status

    // control register bit positions
    localparam int CB_EN  = 0;
    localparam int CB_STA = 1;
    localparam int CB_STO = 2;
    localparam int CB_ACK = 3;
    localparam int CB_IRQ = 7;

    // status codes
    localparam logic [7:0] ST_START   = 8'h08;
    localparam logic [7:0] ST_RSTART  = 8'h10;
    localparam logic [7:0] ST_WA_ACK  = 8'h18;
    localparam logic [7:0] ST_WA_NACK = 8'h20;
    localparam logic [7:0] ST_WD_ACK  = 8'h28;
    localparam logic [7:0] ST_WD_NACK = 8'h30;
    localparam logic [7:0] ST_RA_ACK  = 8'h40;
    localparam logic [7:0] ST_RA_NACK = 8'h48;
    localparam logic [7:0] ST_RD_ACK  = 8'h50;
    localparam logic [7:0] ST_RD_NACK = 8'h58;
    localparam logic [7:0] ST_IDLE    = 8'hF8;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_ADDR  = 3'd1,
        EV_WRITE = 3'd2,
        EV_READ  = 3'd3,
        EV_STOP  = 3'd4
    } twm_evt_e;

endpackage

// File: rtl/twm_regs.sv
// Module: control register with edge detection.
// Holds enable, start, stop and acknowledge-enable. It turns each control write
// into single-cycle command pulses that act in the same cycle as the write.
// Assumes the data-register write and the control write never coincide
// (one shared write port).
module twm_regs
    import twm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_q,
    output logic              en_q,
    output logic              sta_q,
    output logic              sto_q,
    output logic              ack_en_q,
    output logic              ack_en_nxt,
    output logic              dis_p,
    output logic              sta_rise_p,
    output logic              sto_rise_p,
    output logic              irq_clr_p,
    output logic              step_p,
    output logic              data_wr_p
);

    logic ctrl_wr;
    logic live;
    logic unused_bits;

    assign unused_bits = ^wr_data[6:4];

    // decode command pulses from the current write and the stored bits
    always_comb begin
        ctrl_wr    = wr_en && !wr_sel;
        data_wr_p  = wr_en && wr_sel;
        live       = ctrl_wr && wr_data[CB_EN];
        dis_p      = ctrl_wr && en_q && !wr_data[CB_EN];
        sta_rise_p = live && !sta_q && wr_data[CB_STA];
        sto_rise_p = live && !sto_q && wr_data[CB_STO];
        irq_clr_p  = live && irq_q && wr_data[CB_IRQ];
        step_p     = irq_clr_p && !wr_data[CB_STA] && !wr_data[CB_STO];
        ack_en_nxt = live ? wr_data[CB_ACK] : ack_en_q;
    end

    // store the control bits; a disable clears them, other disabled writes keep them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            sta_q    <= 1'b0;
            sto_q    <= 1'b0;
            ack_en_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q <= wr_data[CB_EN];
            if (live) begin
                sta_q    <= wr_data[CB_STA];
                sto_q    <= wr_data[CB_STO];
                ack_en_q <= wr_data[CB_ACK];
            end else if (dis_p) begin
                sta_q    <= 1'b0;
                sto_q    <= 1'b0;
                ack_en_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/twm_seq.sv
// Module: transaction sequencer.
// Tracks start-active, address-sent and the read/write permission flags.
// Emits the combinational peer event and selects the status code to post.
// Assumes the peer answers acknowledge and read data in the event cycle.
module twm_seq
    import twm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dis_p,
    input  logic              sta_rise_p,
    input  logic              sto_rise_p,
    input  logic              step_p,
    input  logic              data_wr_p,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_en_nxt,
    input  logic              peer_ack,
    input  logic [DATA_W-1:0] peer_rdata,
    output logic              evt_valid,
    output twm_evt_e          evt_kind,
    output logic [DATA_W-1:0] evt_addr,
    output logic [DATA_W-1:0] evt_data,
    output logic              evt_ack,
    output logic [DATA_W-1:0] data_q,
    output logic              post_p,
    output logic [7:0]        post_code,
    output logic              post_long
);

    logic              start_act;
    logic              addr_sent;
    logic              rd_perm;
    logic              wr_perm;
    logic [DATA_W-1:0] peer_addr;

    logic is_read;
    logic addr_step;
    logic data_go;
    logic stop_evt;

    // classify the step requested this cycle
    always_comb begin
        is_read   = peer_addr[0];
        addr_step = step_p && !addr_sent;
        data_go   = step_p && addr_sent && (is_read ? rd_perm : wr_perm);
        stop_evt  = sto_rise_p && start_act;
    end

    // build the peer event
    always_comb begin
        evt_valid = stop_evt || addr_step || data_go;
        evt_kind  = EV_NONE;
        if (stop_evt)       evt_kind = EV_STOP;
        else if (addr_step) evt_kind = EV_ADDR;
        else if (data_go)   evt_kind = is_read ? EV_READ : EV_WRITE;
        evt_addr = addr_step ? data_q : peer_addr;
        evt_data = (data_go && !is_read) ? data_q : '0;
        evt_ack  = data_go && is_read && ack_en_nxt;
    end

    // choose the status code and its delay class
    always_comb begin
        post_p    = sta_rise_p || addr_step || data_go;
        post_long = !sta_rise_p;
        post_code = ST_IDLE;
        if (sta_rise_p)
            post_code = start_act ? ST_RSTART : ST_START;
        else if (addr_step)
            post_code = data_q[0] ? (peer_ack ? ST_RA_ACK : ST_RA_NACK)
                                  : (peer_ack ? ST_WA_ACK : ST_WA_NACK);
        else if (data_go)
            post_code = is_read ? (ack_en_nxt ? ST_RD_ACK : ST_RD_NACK)
                                : (peer_ack ? ST_WD_ACK : ST_WD_NACK);
    end

    // update the transaction state and the data register
    always_ff @(posedge clk) begin
        if (!rst_n || dis_p) begin
            start_act <= 1'b0;
            addr_sent <= 1'b0;
            rd_perm   <= 1'b0;
            wr_perm   <= 1'b0;
            peer_addr <= '0;
            data_q    <= '1;
        end else begin
            if (data_wr_p) begin
                data_q  <= wr_data;
                wr_perm <= 1'b1;
            end
            if (sto_rise_p) begin
                start_act <= 1'b0;
                addr_sent <= 1'b0;
                rd_perm   <= 1'b0;
                wr_perm   <= 1'b0;
            end
            if (sta_rise_p) begin
                start_act <= 1'b1;
                addr_sent <= 1'b0;
                rd_perm   <= 1'b0;
                wr_perm   <= 1'b0;
                peer_addr <= '0;
            end
            if (step_p) begin
                wr_perm <= 1'b0;
                if (addr_step) begin
                    addr_sent <= 1'b1;
                    peer_addr <= data_q;
                    if (data_q[0]) rd_perm <= 1'b1;
                end
                if (data_go && is_read) data_q <= peer_rdata;
            end
        end
    end

endmodule

// File: rtl/twm_status.sv
// Module: delayed status poster and interrupt flag.
// Holds one pending status with a down-counter and posts it, raising the flag,
// when the count runs out. A new post replaces a pending one; a disable
// cancels it. Assumes BIT_CYCLES >= 1.
module twm_status
    import twm_pkg::*;
#(
    parameter int BIT_CYCLES = 10
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       post_p,
    input  logic [7:0] post_code,
    input  logic       post_long,
    input  logic       dis_p,
    input  logic       irq_clr_p,
    output logic [7:0] status_q,
    output logic       irq_q,
    output logic       pend_q
);

    localparam int LONG_CYC  = BYTE_BITS * BIT_CYCLES;
    localparam int SHORT_CYC = START_BITS * BIT_CYCLES;
    localparam int CW        = $clog2(LONG_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic [7:0]    code_q;

    // load, count down and post the pending status
    always_ff @(posedge clk) begin
        if (!rst_n || dis_p) begin
            pend_q   <= 1'b0;
            cnt_q    <= '0;
            code_q   <= ST_IDLE;
            status_q <= ST_IDLE;
            irq_q    <= 1'b0;
        end else begin
            if (irq_clr_p) irq_q <= 1'b0;
            if (post_p) begin
                pend_q <= 1'b1;
                code_q <= post_code;
                cnt_q  <= post_long ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
            end else if (pend_q) begin
                if (cnt_q == '0) begin
                    pend_q   <= 1'b0;
                    status_q <= code_q;
                    irq_q    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/twm_ctrl.sv
// Module: two-wire bus master transaction controller (top).
// Ties together the control register, the transaction sequencer and the
// delayed status poster. One bit-time is BIT_CYCLES clock cycles.
module twm_ctrl
    import twm_pkg::*;
#(
    parameter int BIT_CYCLES = 10
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       ctl_en,
    output logic       ctl_start,
    output logic       ctl_stop,
    output logic       ctl_ack_en,
    output logic       irq,
    output logic [7:0] data_q,
    output logic [7:0] status_q,
    output logic       evt_valid,
    output logic [2:0] evt_kind,
    output logic [7:0] evt_addr,
    output logic [7:0] evt_data,
    output logic       evt_ack,
    input  logic       peer_ack,
    input  logic [7:0] peer_rdata
);

    logic       ack_en_nxt;
    logic       dis_p;
    logic       sta_rise_p;
    logic       sto_rise_p;
    logic       irq_clr_p;
    logic       step_p;
    logic       data_wr_p;
    logic       post_p;
    logic [7:0] post_code;
    logic       post_long;
    logic       pend_q;
    twm_evt_e   kind_e;

    assign evt_kind = kind_e;

    twm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .irq_q      (irq),
        .en_q       (ctl_en),
        .sta_q      (ctl_start),
        .sto_q      (ctl_stop),
        .ack_en_q   (ctl_ack_en),
        .ack_en_nxt (ack_en_nxt),
        .dis_p      (dis_p),
        .sta_rise_p (sta_rise_p),
        .sto_rise_p (sto_rise_p),
        .irq_clr_p  (irq_clr_p),
        .step_p     (step_p),
        .data_wr_p  (data_wr_p)
    );

    twm_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dis_p      (dis_p),
        .sta_rise_p (sta_rise_p),
        .sto_rise_p (sto_rise_p),
        .step_p     (step_p),
        .data_wr_p  (data_wr_p),
        .wr_data    (wr_data),
        .ack_en_nxt (ack_en_nxt),
        .peer_ack   (peer_ack),
        .peer_rdata (peer_rdata),
        .evt_valid  (evt_valid),
        .evt_kind   (kind_e),
        .evt_addr   (evt_addr),
        .evt_data   (evt_data),
        .evt_ack    (evt_ack),
        .data_q     (data_q),
        .post_p     (post_p),
        .post_code  (post_code),
        .post_long  (post_long)
    );

    twm_status #(.BIT_CYCLES(BIT_CYCLES)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_p    (post_p),
        .post_code (post_code),
        .post_long (post_long),
        .dis_p     (dis_p),
        .irq_clr_p (irq_clr_p),
        .status_q  (status_q),
        .irq_q     (irq),
        .pend_q    (pend_q)
    );

endmodule

// File: rtl/twm_ctrl_sva.sv
// Module: assertion checker for twm_ctrl, attached by bind.
// Measures status delays with its own counter and tracks start activity
// from posted start commands.
module twm_ctrl_sva
    import twm_pkg::*;
#(
    parameter int BIT_CYCLES = 10
)(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic       ctl_en,
    input logic       ctl_start,
    input logic       ctl_stop,
    input logic       ctl_ack_en,
    input logic       irq,
    input logic [7:0] data_q,
    input logic [7:0] status_q,
    input logic       evt_valid,
    input logic [2:0] evt_kind,
    input logic       post_p,
    input logic       post_long,
    input logic       pend_q
);

    localparam logic [15:0] LONG_LEN  = 16'(BYTE_BITS * BIT_CYCLES);
    localparam logic [15:0] SHORT_LEN = 16'(START_BITS * BIT_CYCLES);

    logic [15:0] age;
    logic [15:0] exp_len;
    logic        start_seen;
    logic        unused_bits;

    assign unused_bits = ^{wr_data[6:1]};

    // age of the latest posted command, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age     <= 16'hFFFF;
            exp_len <= 16'd0;
        end else if (post_p) begin
            age     <= 16'd0;
            exp_len <= post_long ? LONG_LEN : SHORT_LEN;
        end else if (age != 16'hFFFF) begin
            age <= age + 16'd1;
        end
    end

    // a start has been commanded and not yet ended by stop or disable
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_en)
            start_seen <= 1'b0;
        else if (post_p && !post_long)
            start_seen <= 1'b1;
        else if (evt_valid && evt_kind == EV_STOP)
            start_seen <= 1'b0;
    end

    a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_en) |-> (data_q == 8'hFF && status_q == ST_IDLE && !irq
                           && !ctl_start && !ctl_stop && !ctl_ack_en));

    a_r3_no_event_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> ctl_en);

    a_r4_stop_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == EV_STOP) |-> start_seen);

    a_r5_post_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (age == exp_len));

    a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[CB_EN] && wr_data[CB_IRQ] && ctl_en
         && irq && !pend_q) |=> !irq);

endmodule

bind twm_ctrl twm_ctrl_sva #(.BIT_CYCLES(BIT_CYCLES)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .ctl_en     (ctl_en),
    .ctl_start  (ctl_start),
    .ctl_stop   (ctl_stop),
    .ctl_ack_en (ctl_ack_en),
    .irq        (irq),
    .data_q     (data_q),
    .status_q   (status_q),
    .evt_valid  (evt_valid),
    .evt_kind   (evt_kind),
    .post_p     (post_p),
    .post_long  (post_long),
    .pend_q     (pend_q)
);

// File: tb/twm_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed corner tests.
module twm_ctrl_tb;

    localparam int BITC = 2;
    localparam int NV   = 25;

    typedef struct packed {
        logic       sel;
        logic [7:0] val;
        logic       pack;
        logic [7:0] prd;
        logic [2:0] ek;
        logic [7:0] ev;
        logic [7:0] es;
        logic [3:0] dly;
    } vec_t;

    // sel, value, peer_ack, peer_rdata, event kind, event value, status, delay bits
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 8'h01, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 4'd0},
        '{1'b0, 8'h03, 1'b0, 8'h00, 3'd0, 8'h00, 8'h08, 4'd3},
        '{1'b1, 8'hA4, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 4'd0},
        '{1'b0, 8'h81, 1'b1, 8'h00, 3'd1, 8'hA4, 8'h18, 4'd9},
        '{1'b1, 8'h3C, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 4'd0},
        '{1'b0, 8'h81, 1'b1, 8'h00, 3'd2, 8'h3C, 8'h28, 4'd9},
        '{1'b1, 8'h5A, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 4'd0},
        '{1'b0, 8'h81, 1'b0, 8'h00, 3'd2, 8'h5A, 8'h30, 4'd9},
        '{1'b0, 8'h81, 1'b1, 8'h00, 3'd0, 8'h00, 8'h00, 4'd0},
        '{1'b0, 8'h0B, 1'b0, 8'h00, 3'd0, 8'h00, 8'h10, 4'd3},
        '{1'b1, 8'hA5, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 4'd0},
        '{1'b0, 8'h89, 1'b1, 8'h00, 3'd1, 8'hA5, 8'h40, 4'd9},
        '{1'b0, 8'h89, 1'b0, 8'h77, 3'd3, 8'h77, 8'h50, 4'd9},
        '{1'b0, 8'h81, 1'b1, 8'h99, 3'd3, 8'h99, 8'h58, 4'd9},
        '{1'b0, 8'h05, 1'b0, 8'h00, 3'd4, 8'hA5, 8'h00, 4'd0},
        '{1'b0, 8'h03, 1'b0, 8'h00, 3'd0, 8'h00, 8'h08, 4'd3},
        '{1'b1, 8'hA7, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 4'd0},
        '{1'b0, 8'h81, 1'b0, 8'h00, 3'd1, 8'hA7, 8'h48, 4'd9},
        '{1'b0, 8'h05, 1'b0, 8'h00, 3'd4, 8'hA7, 8'h00, 4'd0},
        '{1'b0, 8'h03, 1'b0, 8'h00, 3'd0, 8'h00, 8'h08, 4'd3},
        '{1'b1, 8'h20, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 4'd0},
        '{1'b0, 8'h81, 1'b0, 8'h00, 3'd1, 8'h20, 8'h20, 4'd9},
        '{1'b0, 8'h05, 1'b0, 8'h00, 3'd4, 8'h20, 8'h00, 4'd0},
        '{1'b0, 8'h01, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 4'd0},
        '{1'b0, 8'h05, 1'b0, 8'h00, 3'd0, 8'h00, 8'h00, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       peer_ack = 1'b0;
    logic [7:0] peer_rdata = 8'h00;
    logic       ctl_en, ctl_start, ctl_stop, ctl_ack_en, irq;
    logic [7:0] data_q, status_q, evt_addr, evt_data;
    logic       evt_valid, evt_ack;
    logic [2:0] evt_kind;

    int         nchk = 0;
    int         nfail = 0;
    bit         done = 1'b0;
    int         ev_cnt;
    logic [2:0] ev_kind;
    logic [7:0] ev_addr, ev_data;
    logic       ev_ack;

    always #2 clk = ~clk;

    twm_ctrl #(.BIT_CYCLES(BITC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctl_en(ctl_en), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .ctl_ack_en(ctl_ack_en), .irq(irq), .data_q(data_q), .status_q(status_q),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_addr(evt_addr),
        .evt_data(evt_data), .evt_ack(evt_ack), .peer_ack(peer_ack),
        .peer_rdata(peer_rdata)
    );

    // peer-side recorder of emitted events
    always @(posedge clk) begin
        if (!rst_n) begin
            ev_cnt <= 0;
        end else if (evt_valid) begin
            ev_cnt  <= ev_cnt + 1;
            ev_kind <= evt_kind;
            ev_addr <= evt_addr;
            ev_data <= evt_data;
            ev_ack  <= evt_ack;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic sel, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_post(input logic [7:0] code, input int d, input string tag,
                               input logic [7:0] prev);
        repeat (d - 1) @(posedge clk);
        @(negedge clk);
        chk(status_q == prev, {tag, " early status"}, status_q, prev);
        @(posedge clk);
        @(negedge clk);
        chk(status_q == code, {tag, " status"}, status_q, code);
        chk(irq == 1'b1, {tag, " irq raised"}, irq, 1);
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [2:0] ek, input logic [3:0] dly);
        case (ek)
            3'd1:    return "R6";
            3'd2:    return "R8";
            3'd3:    return "R9";
            3'd4:    return "R4";
            default: return (dly != 0) ? "R5" : "R8";
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        int n0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!ctl_en && !ctl_start && !ctl_stop && !ctl_ack_en, "R1 ctl bits",
            {ctl_en, ctl_start, ctl_stop, ctl_ack_en}, 0);
        chk(!irq, "R1 irq", irq, 0);
        chk(data_q == 8'hFF, "R1 data", data_q, 8'hFF);
        chk(status_q == 8'hF8, "R1 status", status_q, 8'hF8);
        chk(!evt_valid, "R1 no event", evt_valid, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VECS[i];
            t = tag_of(v.ek, v.dly);
            peer_ack = v.pack;
            peer_rdata = v.prd;
            prev = status_q;
            n0 = ev_cnt;
            cpu_wr(v.sel, v.val);
            if (v.ek != 0) begin
                chk(ev_cnt == n0 + 1, {t, " event count"}, ev_cnt, n0 + 1);
                chk(ev_kind == v.ek, {t, " event kind"}, ev_kind, v.ek);
                case (v.ek)
                    3'd2: chk(ev_data == v.ev, {t, " write byte"}, ev_data, v.ev);
                    3'd3: begin
                        chk(data_q == v.ev, {t, " read byte"}, data_q, v.ev);
                        chk(ev_ack == v.val[3], {t, " read ack"}, ev_ack, v.val[3]);
                    end
                    default: chk(ev_addr == v.ev, {t, " event addr"}, ev_addr, v.ev);
                endcase
            end else begin
                chk(ev_cnt == n0, {t, " no event"}, ev_cnt, n0);
            end
            if (v.dly != 0) begin
                expect_post(v.es, int'(v.dly) * BITC, (v.ek == 1) ? "R7" : t, prev);
            end else begin
                idle_wait(20);
                chk(status_q == prev, {t, " no status"}, status_q, prev);
                chk(ev_cnt == n0 + ((v.ek != 0) ? 1 : 0), {t, " events settled"},
                    ev_cnt, n0);
            end
        end

        // R10: writing 0 to the flag keeps it, writing 1 clears it
        cpu_wr(1'b0, 8'h01);
        chk(irq == 1'b1, "R10 irq kept", irq, 1);
        peer_ack = 1'b0;
        cpu_wr(1'b0, 8'h81);
        chk(irq == 1'b0, "R10 irq cleared", irq, 0);
        idle_wait(9 * BITC + 2);

        // R12: clear with start set: no byte step, start status only
        n0 = ev_cnt;
        prev = status_q;
        cpu_wr(1'b0, 8'h83);
        chk(ev_cnt == n0, "R12 no event", ev_cnt, n0);
        expect_post(8'h08, 3 * BITC, "R12", prev);

        // R11: pending read-address status replaced by a repeated start
        cpu_wr(1'b1, 8'h21);
        peer_ack = 1'b1;
        cpu_wr(1'b0, 8'h81);
        cpu_wr(1'b0, 8'h03);
        expect_post(8'h10, 3 * BITC, "R11", 8'h08);
        idle_wait(9 * BITC + 4);
        chk(status_q == 8'h10, "R11 old status dropped", status_q, 8'h10);

        // R2: disable cancels a pending start status and clears state
        cpu_wr(1'b0, 8'h05);
        cpu_wr(1'b0, 8'h0B);
        cpu_wr(1'b0, 8'h00);
        chk(!ctl_en && !ctl_start && !ctl_stop && !ctl_ack_en, "R2 ctl bits",
            {ctl_en, ctl_start, ctl_stop, ctl_ack_en}, 0);
        chk(irq == 1'b0, "R2 irq", irq, 0);
        chk(data_q == 8'hFF, "R2 data", data_q, 8'hFF);
        chk(status_q == 8'hF8, "R2 status", status_q, 8'hF8);
        idle_wait(4 * BITC);
        chk(status_q == 8'hF8 && !irq, "R2 pending dropped", status_q, 8'hF8);

        // R3: disabled writes are ignored
        n0 = ev_cnt;
        cpu_wr(1'b0, 8'h86);
        chk(!ctl_start && !ctl_stop, "R3 bits unchanged", {ctl_start, ctl_stop}, 0);
        idle_wait(4 * BITC);
        chk(status_q == 8'hF8 && !irq, "R3 no status", status_q, 8'hF8);
        chk(ev_cnt == n0, "R3 no event", ev_cnt, n0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule